// File: doc/BRIEF.md
# Three-Input Tagged Operand Matcher

This block pairs up operand tokens for a single dataflow operator that takes two or three operands. Every token brings a data word and a tag built from an activation field, a nesting field and an iteration field. The block keeps one holding register per operand input. Once every active input holds a token and all of those tags are equal, the block offers the whole set to the operator's firing logic in one transfer.

A token can conflict with what is already held. This happens when its tag differs from an occupied register, or when its own input's register is already full. Such a token is not stored. It goes straight out on a spill port, where an external allocator uses it to start a fresh operator instance. Inputs, the fire output and the spill output each use a valid/ready handshake. At most one input token is handled per cycle. A is served first, then B, then C.

Top module: `tok_match_unit`

## Requirements
- R1: After reset every holding register is empty, `fire_valid` is low and `spill_valid` is low.
- R2: A token offered to an empty unit is taken in the same cycle (its ready is high) and stored. No fire is offered until the set is complete.
- R3: A token whose tag equals every occupied register's tag, arriving on an input whose own register is empty, is stored. When the last active input is filled, `fire_valid` rises in the cycle after that token's handshake. It presents the common tag and each input's data on `fire_a`, `fire_b`, `fire_c`.
- R4: While `fire_valid` is high and `fire_ready` is low, the fire outputs hold steady. On the cycle the set is accepted, all holding flags clear together, so `fire_valid` is low on the next cycle.
- R5: A token whose tag differs from any occupied register is offered on the spill port in the same cycle. The port carries `spill_port` (A=0, B=1, C=2), the tag and the data. The held registers stay unchanged, so the held set can still complete and fire with its original tag and data.
- R6: A token arriving on an input whose own register is already occupied is spilled, even when its tag equals the held tag.
- R7: While a conflicting token waits and `spill_ready` is low, that input's ready is low. The token is kept on the spill port until `spill_ready` rises, and it is never lost.
- R8: When several inputs are valid in the same cycle, only one handshake occurs per cycle. The order is A, then B, then C: a valid A blocks B and C, and a valid B blocks C.
- R9: With `NUM_IN`=2, a set is complete with A and B alone. `c_ready` stays low, input C is ignored, and `fire_c` is zero.
- R10: Tag equality covers all three fields. The tag is packed as {activation, nesting, iteration}, most significant first. Two tags that differ only in the nesting field conflict.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| a_valid | input | 1 | Token offered on input A |
| a_ready | output | 1 | Input A token taken this cycle |
| a_tag | input | TAG_W | Tag of input A token |
| a_data | input | DATA_W | Data of input A token |
| b_valid | input | 1 | Token offered on input B |
| b_ready | output | 1 | Input B token taken this cycle |
| b_tag | input | TAG_W | Tag of input B token |
| b_data | input | DATA_W | Data of input B token |
| c_valid | input | 1 | Token offered on input C |
| c_ready | output | 1 | Input C token taken this cycle |
| c_tag | input | TAG_W | Tag of input C token |
| c_data | input | DATA_W | Data of input C token |
| fire_valid | output | 1 | Complete matched set available |
| fire_ready | input | 1 | Firing logic accepts the set |
| fire_tag | output | TAG_W | Common tag of the set |
| fire_a | output | DATA_W | Operand from input A |
| fire_b | output | DATA_W | Operand from input B |
| fire_c | output | DATA_W | Operand from input C (zero in two-input mode) |
| spill_valid | output | 1 | Conflicting token offered to the allocator |
| spill_ready | input | 1 | Allocator accepts the spilled token |
| spill_port | output | 2 | Input the spilled token came from |
| spill_tag | output | TAG_W | Tag of the spilled token |
| spill_data | output | DATA_W | Data of the spilled token |

## Verification
Spill results appear in the same cycle as the offending token, because the spill path is combinational. Ready is also combinational. The fire output rises one register stage after the handshake of the completing token, and it falls one cycle after it is accepted. The bench drives inputs one time unit after the rising edge and samples at the falling edge. It checks spill and ready values in the cycle the token is offered, and it checks fire values at the falling edge after the completing handshake edge. A scoreboard pops expected fire and spill items whenever a handshake is visible at that falling edge.

// File: rtl/tmu_pkg.sv
package tmu_pkg;

  localparam int PORTS = 3;

  // lowest-index request wins
  function automatic logic [PORTS-1:0] first_req(input logic [PORTS-1:0] req);
    logic [PORTS-1:0] oh;
    oh = '0;
    for (int i = PORTS - 1; i >= 0; i--) begin
      if (req[i]) oh = '0;
      if (req[i]) oh[i] = 1'b1;
    end
    return oh;
  endfunction

  function automatic logic [1:0] oh_to_idx(input logic [PORTS-1:0] oh);
    logic [1:0] idx;
    idx = 2'd0;
    for (int i = 0; i < PORTS; i++)
      if (oh[i]) idx = 2'(i);
    return idx;
  endfunction

endpackage

// File: rtl/tmu_pick.sv
module tmu_pick
  import tmu_pkg::*;
(
  input  logic [PORTS-1:0] req,
  output logic [PORTS-1:0] grant_oh,
  output logic [1:0]       grant_idx,
  output logic             any_req
);
  always_comb begin
    grant_oh  = first_req(req);
    grant_idx = oh_to_idx(grant_oh);
    any_req   = |req;
  end
endmodule

// File: rtl/tmu_slot.sv
module tmu_slot #(
  parameter int TAG_W  = 20,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic              clear,
  input  logic [TAG_W-1:0]  d_tag,
  input  logic [DATA_W-1:0] d_data,
  output logic              q_vld,
  output logic [TAG_W-1:0]  q_tag,
  output logic [DATA_W-1:0] q_data
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      q_vld  <= 1'b0;
      q_tag  <= '0;
      q_data <= '0;
    end else if (clear) begin
      q_vld <= 1'b0;
    end else if (load) begin
      q_vld  <= 1'b1;
      q_tag  <= d_tag;
      q_data <= d_data;
    end
  end
endmodule

// File: rtl/tmu_compare.sv
module tmu_compare
  import tmu_pkg::*;
#(
  parameter int TAG_W = 20
) (
  input  logic [PORTS-1:0]            held_vld,
  input  logic [PORTS-1:0][TAG_W-1:0] held_tag,
  input  logic [PORTS-1:0]            cand_oh,
  input  logic [TAG_W-1:0]            cand_tag,
  output logic                        clash
);
  logic [PORTS-1:0] tag_diff;
  logic             own_busy;

  for (genvar i = 0; i < PORTS; i++) begin : g_cmp
    assign tag_diff[i] = held_vld[i] && (held_tag[i] != cand_tag);
  end

  assign own_busy = |(held_vld & cand_oh);
  assign clash    = own_busy || (|tag_diff);
endmodule

// File: rtl/tok_match_unit.sv
module tok_match_unit
  import tmu_pkg::*;
#(
  parameter int ACT_W  = 8,
  parameter int NEST_W = 4,
  parameter int ITER_W = 8,
  parameter int DATA_W = 32,
  parameter int NUM_IN = 3,
  localparam int TAG_W = ACT_W + NEST_W + ITER_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              a_valid,
  output logic              a_ready,
  input  logic [TAG_W-1:0]  a_tag,
  input  logic [DATA_W-1:0] a_data,
  input  logic              b_valid,
  output logic              b_ready,
  input  logic [TAG_W-1:0]  b_tag,
  input  logic [DATA_W-1:0] b_data,
  input  logic              c_valid,
  output logic              c_ready,
  input  logic [TAG_W-1:0]  c_tag,
  input  logic [DATA_W-1:0] c_data,
  output logic              fire_valid,
  input  logic              fire_ready,
  output logic [TAG_W-1:0]  fire_tag,
  output logic [DATA_W-1:0] fire_a,
  output logic [DATA_W-1:0] fire_b,
  output logic [DATA_W-1:0] fire_c,
  output logic              spill_valid,
  input  logic              spill_ready,
  output logic [1:0]        spill_port,
  output logic [TAG_W-1:0]  spill_tag,
  output logic [DATA_W-1:0] spill_data
);
  localparam logic [PORTS-1:0] ACT_MASK = (NUM_IN >= 3) ? 3'b111 : 3'b011;

  logic [PORTS-1:0]             req;
  logic [PORTS-1:0]             cand_oh;
  logic [1:0]                   cand_idx;
  logic                         cand_any;
  logic [PORTS-1:0][TAG_W-1:0]  in_tag;
  logic [PORTS-1:0][DATA_W-1:0] in_data;
  logic [TAG_W-1:0]             cand_tag;
  logic [DATA_W-1:0]            cand_data;
  logic                         clash;
  logic [PORTS-1:0]             held_vld;
  logic [PORTS-1:0][TAG_W-1:0]  held_tag;
  logic [PORTS-1:0][DATA_W-1:0] held_data;
  logic [PORTS-1:0]             grant;
  logic [PORTS-1:0]             load;

  // named events
  logic ev_store;
  logic ev_spill;
  logic ev_fire;

  assign req     = {c_valid, b_valid, a_valid} & ACT_MASK;
  assign in_tag  = {c_tag, b_tag, a_tag};
  assign in_data = {c_data, b_data, a_data};

  tmu_pick u_pick (
    .req       (req),
    .grant_oh  (cand_oh),
    .grant_idx (cand_idx),
    .any_req   (cand_any)
  );

  assign cand_tag  = in_tag[cand_idx];
  assign cand_data = in_data[cand_idx];

  tmu_compare #(.TAG_W(TAG_W)) u_cmp (
    .held_vld (held_vld),
    .held_tag (held_tag),
    .cand_oh  (cand_oh),
    .cand_tag (cand_tag),
    .clash    (clash)
  );

  assign ev_store = cand_any && !clash;
  assign ev_spill = cand_any && clash && spill_ready;
  assign load     = cand_oh & {PORTS{!clash}};
  assign grant    = cand_oh & {PORTS{!clash || spill_ready}};

  assign fire_valid = &(held_vld | ~ACT_MASK);
  assign ev_fire    = fire_valid && fire_ready;

  for (genvar i = 0; i < PORTS; i++) begin : g_slot
    if (i < NUM_IN) begin : g_on
      tmu_slot #(.TAG_W(TAG_W), .DATA_W(DATA_W)) u_slot (
        .clk    (clk),
        .rst_n  (rst_n),
        .load   (load[i]),
        .clear  (ev_fire),
        .d_tag  (cand_tag),
        .d_data (cand_data),
        .q_vld  (held_vld[i]),
        .q_tag  (held_tag[i]),
        .q_data (held_data[i])
      );
    end else begin : g_off
      assign held_vld[i]  = 1'b0;
      assign held_tag[i]  = '0;
      assign held_data[i] = '0;
    end
  end

  assign a_ready = grant[0];
  assign b_ready = grant[1];
  assign c_ready = grant[2];

  assign fire_tag = held_tag[0];
  assign fire_a   = held_data[0];
  assign fire_b   = held_data[1];
  assign fire_c   = held_data[2];

  assign spill_valid = cand_any && clash;
  assign spill_port  = cand_idx;
  assign spill_tag   = cand_tag;
  assign spill_data  = cand_data;
endmodule

// File: rtl/tmu_checker.sv
module tmu_checker #(
  parameter int TAG_W  = 20,
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              a_valid,
  input logic              a_ready,
  input logic              b_valid,
  input logic              b_ready,
  input logic              c_valid,
  input logic              c_ready,
  input logic              fire_valid,
  input logic              fire_ready,
  input logic [TAG_W-1:0]  fire_tag,
  input logic [DATA_W-1:0] fire_a,
  input logic [DATA_W-1:0] fire_b,
  input logic [DATA_W-1:0] fire_c,
  input logic              spill_valid,
  input logic              spill_ready
);
  logic was_rst = 1'b0;

  always_ff @(posedge clk) begin
    if (was_rst) begin
      assert_reset_R1: assert (!fire_valid)
        else $error("fire_valid high right after reset");
    end
    was_rst <= !rst_n;
  end

  assert_one_grant_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({a_valid && a_ready, b_valid && b_ready, c_valid && c_ready}));

  assert_order_a_R8: assert property (@(posedge clk) disable iff (!rst_n)
    a_valid |-> !b_ready && !c_ready);

  assert_order_b_R8: assert property (@(posedge clk) disable iff (!rst_n)
    b_valid |-> !c_ready);

  assert_fire_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    fire_valid && !fire_ready |=> fire_valid && $stable(fire_tag) &&
      $stable(fire_a) && $stable(fire_b) && $stable(fire_c));

  assert_fire_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
    fire_valid && fire_ready |=> !fire_valid);

  assert_spill_stall_R7: assert property (@(posedge clk) disable iff (!rst_n)
    spill_valid && !spill_ready |-> !a_ready && !b_ready && !c_ready);

  assert_spill_keep_R5: assert property (@(posedge clk) disable iff (!rst_n)
    spill_valid && spill_ready && !fire_valid |=> !fire_valid);
endmodule

bind tok_match_unit tmu_checker #(.TAG_W(TAG_W), .DATA_W(DATA_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .a_valid     (a_valid),
  .a_ready     (a_ready),
  .b_valid     (b_valid),
  .b_ready     (b_ready),
  .c_valid     (c_valid),
  .c_ready     (c_ready),
  .fire_valid  (fire_valid),
  .fire_ready  (fire_ready),
  .fire_tag    (fire_tag),
  .fire_a      (fire_a),
  .fire_b      (fire_b),
  .fire_c      (fire_c),
  .spill_valid (spill_valid),
  .spill_ready (spill_ready)
);

// File: tb/sim_tok_match_unit.sv
module sim_tok_match_unit;
  localparam int TW = 20;
  localparam int DW = 32;

  typedef struct packed {
    logic [TW-1:0] tag;
    logic [DW-1:0] a;
    logic [DW-1:0] b;
    logic [DW-1:0] c;
  } fire_t;

  typedef struct packed {
    logic [1:0]    port;
    logic [TW-1:0] tag;
    logic [DW-1:0] data;
  } spill_t;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  int total = 0;
  int bad = 0;

  // instance u0: three inputs
  logic          in_v [3];
  logic          in_r [3];
  logic [TW-1:0] in_t [3];
  logic [DW-1:0] in_d [3];
  logic          fv, fr, sv, sr;
  logic [TW-1:0] ft, st;
  logic [DW-1:0] fa, fb, fc, sd;
  logic [1:0]    sp;

  tok_match_unit u0 (
    .clk(clk), .rst_n(rst_n),
    .a_valid(in_v[0]), .a_ready(in_r[0]), .a_tag(in_t[0]), .a_data(in_d[0]),
    .b_valid(in_v[1]), .b_ready(in_r[1]), .b_tag(in_t[1]), .b_data(in_d[1]),
    .c_valid(in_v[2]), .c_ready(in_r[2]), .c_tag(in_t[2]), .c_data(in_d[2]),
    .fire_valid(fv), .fire_ready(fr), .fire_tag(ft),
    .fire_a(fa), .fire_b(fb), .fire_c(fc),
    .spill_valid(sv), .spill_ready(sr), .spill_port(sp),
    .spill_tag(st), .spill_data(sd)
  );

  // instance u2: two inputs
  logic          n_av, n_ar, n_bv, n_br, n_cv, n_cr, n_fv, n_sv;
  logic [TW-1:0] n_at, n_bt, n_ct, n_ft, n_st;
  logic [DW-1:0] n_ad, n_bd, n_cd, n_fa, n_fb, n_fc, n_sd;
  logic [1:0]    n_sp;

  tok_match_unit #(.NUM_IN(2)) u2 (
    .clk(clk), .rst_n(rst_n),
    .a_valid(n_av), .a_ready(n_ar), .a_tag(n_at), .a_data(n_ad),
    .b_valid(n_bv), .b_ready(n_br), .b_tag(n_bt), .b_data(n_bd),
    .c_valid(n_cv), .c_ready(n_cr), .c_tag(n_ct), .c_data(n_cd),
    .fire_valid(n_fv), .fire_ready(1'b1), .fire_tag(n_ft),
    .fire_a(n_fa), .fire_b(n_fb), .fire_c(n_fc),
    .spill_valid(n_sv), .spill_ready(1'b1), .spill_port(n_sp),
    .spill_tag(n_st), .spill_data(n_sd)
  );

  fire_t  fire_q[$];
  spill_t spill_q[$];

  function automatic logic [TW-1:0] mk(input int act, input int nest, input int iter);
    return {act[7:0], nest[3:0], iter[7:0]};
  endfunction

  task automatic chk(input bit ok, input string req, input logic [127:0] act,
                     input logic [127:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // monitor: pops expectations on visible handshakes
  always @(negedge clk) begin
    if (rst_n) begin
      if (fv && fr) begin
        if (fire_q.size() == 0) chk(1'b0, "R3 unexpected fire", ft, 0);
        else begin
          fire_t e;
          e = fire_q.pop_front();
          chk({ft, fa, fb, fc} == e, "R3 fire set", {ft, fa, fb, fc}, e);
        end
      end
      if (sv && sr) begin
        if (spill_q.size() == 0) chk(1'b0, "R5 unexpected spill", st, 0);
        else begin
          spill_t s;
          s = spill_q.pop_front();
          chk({sp, st, sd} == s, "R5 spill token", {sp, st, sd}, s);
        end
      end
    end
  end

  // driver: starts and ends one time unit after a rising edge
  task automatic send(input int p, input logic [TW-1:0] t, input logic [DW-1:0] d);
    bit got;
    in_v[p] = 1'b1;
    in_t[p] = t;
    in_d[p] = d;
    do begin
      @(negedge clk);
      got = in_r[p];
      @(posedge clk);
      #1;
    end while (!got);
    in_v[p] = 1'b0;
  endtask

  task automatic summary;
    if (fire_q.size() != 0 || spill_q.size() != 0)
      chk(1'b0, "R3 leftover expectations", fire_q.size(), spill_q.size());
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog actual=hung expected=done");
    summary();
  end

  initial begin
    for (int i = 0; i < 3; i++) begin
      in_v[i] = 1'b0; in_t[i] = '0; in_d[i] = '0;
    end
    fr = 1'b1; sr = 1'b1;
    n_av = 0; n_bv = 0; n_cv = 0;
    n_at = '0; n_bt = '0; n_ct = '0; n_ad = '0; n_bd = '0; n_cd = '0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    // R1
    @(negedge clk);
    chk(!fv && !sv, "R1 reset state", {fv, sv}, 0);
    chk(!n_fv, "R1 reset state two-input", n_fv, 0);
    @(posedge clk); #1;

    // R2 / R3: ordered fill
    fire_q.push_back('{mk(1, 2, 3), 32'd10, 32'd20, 32'd30});
    send(0, mk(1, 2, 3), 32'd10);
    @(negedge clk);
    chk(!fv, "R2 no fire after one token", fv, 0);
    @(posedge clk); #1;
    send(1, mk(1, 2, 3), 32'd20);
    @(negedge clk);
    chk(!fv, "R2 no fire after two tokens", fv, 0);
    @(posedge clk); #1;
    send(2, mk(1, 2, 3), 32'd30);
    @(negedge clk);
    chk(fv, "R3 fire one cycle after last token", fv, 1);
    @(posedge clk); #1;

    // R5 / R10: nesting-only difference spills, held set intact
    send(0, mk(4, 1, 9), 32'd1);
    spill_q.push_back('{2'd1, mk(4, 2, 9), 32'd2});
    send(1, mk(4, 2, 9), 32'd2);
    fire_q.push_back('{mk(4, 1, 9), 32'd1, 32'd3, 32'd4});
    send(2, mk(4, 1, 9), 32'd4);
    send(1, mk(4, 1, 9), 32'd3);
    @(negedge clk);
    chk(fv && fa == 32'd1, "R5 held set fires after spill", fa, 1);
    @(posedge clk); #1;

    // R6: duplicate on own input spills even with same tag
    send(0, mk(7, 7, 7), 32'd5);
    spill_q.push_back('{2'd0, mk(7, 7, 7), 32'd6});
    send(0, mk(7, 7, 7), 32'd6);
    fire_q.push_back('{mk(7, 7, 7), 32'd5, 32'd8, 32'd9});
    send(1, mk(7, 7, 7), 32'd8);
    send(2, mk(7, 7, 7), 32'd9);
    @(negedge clk);
    chk(fv && fa == 32'd5, "R6 original A kept", fa, 5);
    @(posedge clk); #1;

    // R7: spill back-pressure
    send(0, mk(9, 0, 1), 32'd11);
    sr = 1'b0;
    in_v[1] = 1'b1; in_t[1] = mk(9, 0, 2); in_d[1] = 32'd12;
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      chk(!in_r[1] && sv && sd == 32'd12, "R7 stalled spill held", {in_r[1], sv}, 1);
      @(posedge clk); #1;
    end
    spill_q.push_back('{2'd1, mk(9, 0, 2), 32'd12});
    sr = 1'b1;
    @(negedge clk);
    chk(in_r[1], "R7 released on spill_ready", in_r[1], 1);
    @(posedge clk); #1;
    in_v[1] = 1'b0;
    fire_q.push_back('{mk(9, 0, 1), 32'd11, 32'd13, 32'd14});
    send(1, mk(9, 0, 1), 32'd13);
    send(2, mk(9, 0, 1), 32'd14);
    @(posedge clk); #1;

    // R4: fire hold under back-pressure and clear on acceptance
    fr = 1'b0;
    send(0, mk(3, 3, 3), 32'd31);
    send(1, mk(3, 3, 3), 32'd32);
    send(2, mk(3, 3, 3), 32'd33);
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      chk(fv && ft == mk(3, 3, 3) && fc == 32'd33, "R4 fire held", {fv, ft}, {1'b1, mk(3, 3, 3)});
      @(posedge clk); #1;
    end
    fire_q.push_back('{mk(3, 3, 3), 32'd31, 32'd32, 32'd33});
    fr = 1'b1;
    @(posedge clk); #1;
    @(negedge clk);
    chk(!fv, "R4 flags cleared after acceptance", fv, 0);
    @(posedge clk); #1;

    // R8: simultaneous arrivals served A, B, C
    for (int i = 0; i < 3; i++) begin
      in_v[i] = 1'b1; in_t[i] = mk(5, 5, 5); in_d[i] = 32'd70 + i;
    end
    fire_q.push_back('{mk(5, 5, 5), 32'd70, 32'd71, 32'd72});
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      chk({in_r[2], in_r[1], in_r[0]} == 3'(1 << k), "R8 one grant in order",
          {in_r[2], in_r[1], in_r[0]}, 1 << k);
      @(posedge clk); #1;
      in_v[k] = 1'b0;
    end
    @(negedge clk);
    chk(fv, "R8 set complete", fv, 1);
    @(posedge clk); #1;

    // R9: two-input mode
    n_cv = 1'b1; n_ct = mk(8, 8, 8); n_cd = 32'd99;
    n_av = 1'b1; n_at = mk(8, 8, 8); n_ad = 32'd80;
    @(negedge clk);
    chk(!n_cr && n_ar, "R9 C ignored, A taken", {n_cr, n_ar}, 1);
    @(posedge clk); #1;
    n_av = 1'b0;
    n_bv = 1'b1; n_bt = mk(8, 8, 8); n_bd = 32'd81;
    @(negedge clk);
    chk(n_br && !n_sv, "R9 B taken", {n_br, n_sv}, 2);
    @(posedge clk); #1;
    n_bv = 1'b0;
    @(negedge clk);
    chk(n_fv && n_fa == 32'd80 && n_fb == 32'd81 && n_fc == '0 && !n_cr,
        "R9 two-input fire", {n_fv, n_fa, n_fb, n_fc}, {1'b1, 32'd80, 32'd81, 32'd0});
    @(posedge clk); #1;
    n_cv = 1'b0;
    repeat (2) @(posedge clk);
    summary();
  end
endmodule